// File: doc/BRIEF.md
# GPIO Line Interrupt Aggregator

This block turns a word of polarity-adjusted GPIO input levels into grouped interrupt requests for two processors. Each line can raise an interrupt in two ways. A level request follows the live input, gated by a per-processor level mask. An edge request comes from a rising transition of the input. That transition is captured in a cause register shared by both processors and gated by a per-processor edge mask. Software gets falling-edge or active-low behaviour by inverting the input before it reaches this block. All detection works on the already-adjusted value.

Software reaches the five registers through a simple byte-addressed register bus with separate write and read strobes. It acknowledges captured edges by writing the cause register: each 0 bit clears the matching cause bit, and each 1 bit leaves it alone. For each processor, the request lines are split into groups of eight. Each group is reduced to one registered output, which gives four outputs per processor at the default width.

Top module: `pin_irq_aggregator`

## Requirements
- R1: After reset, every mask and the cause register read 0, and both interrupt output vectors are 0.
- R2: Registers sit at byte offsets 0x14 (shared edge cause), 0x18 (processor 0 edge mask), 0x1C (processor 0 level mask), 0x30 (processor 1 edge mask) and 0x34 (processor 1 level mask). Address bits [1:0] are ignored. A read strobe updates `reg_rdata` at the next clock edge. Reads of any other offset return 0, and writes to any other offset change nothing.
- R3: A processor's group output is 1 in the cycle after any line of that group is high on `level_in` while its level-mask bit is set. The output falls back in the cycle after the input drops. Nothing is latched.
- R4: A 0-to-1 change of a `level_in` bit, compared with its value on the previous clock, sets that line's cause bit on that edge. A falling input, or an input held high, sets nothing.
- R5: A write to the cause register clears each cause bit whose written bit is 0, and keeps each cause bit whose written bit is 1.
- R6: The edge contribution of a line is its cause bit ANDed with that processor's edge-mask bit. It reaches the group output one clock after the cause bit changes, and it stays asserted after the input falls, until it is acknowledged.
- R7: Output bit g of a processor is the OR of lines 8g to 8g+7 of that processor's combined level and edge request.
- R8: Each processor's masks affect only that processor's outputs. Both processors see the same cause register, so one acknowledge clears the request for both.
- R9: When a new rising edge on a line coincides with a cause write that clears that line, the cause bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_in | input | NLINES | Polarity-adjusted input levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data, valid the cycle after `reg_rd` |
| irq_cpu0 | output | NLINES/GROUP_W | Grouped interrupt requests for processor 0 |
| irq_cpu1 | output | NLINES/GROUP_W | Grouped interrupt requests for processor 1 |

## Verification
Edge capture and the software acknowledge both update the cause register on the same clock edge, and they can hit the same line in the same cycle. The bench provokes this by raising a line on the same clock edge that a cause write carries 0 for every line, including one line that already held a stale event. The read-back must show only the new event: the stale bit is cleared and the colliding bit survives. Around this case, the bench sweeps every line on both processors for the level path and the edge path. It computes each expected group bit as one shifted left by the line index divided by eight.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_CAUSE  = 3'd1,
        SEL_EMASK0 = 3'd2,
        SEL_LMASK0 = 3'd3,
        SEL_EMASK1 = 3'd4,
        SEL_LMASK1 = 3'd5
    } reg_sel_e;

    // Byte offsets; software depends on these positions.
    localparam int unsigned OFS_CAUSE  = 32'h14;
    localparam int unsigned OFS_EMASK0 = 32'h18;
    localparam int unsigned OFS_LMASK0 = 32'h1C;
    localparam int unsigned OFS_EMASK1 = 32'h30;
    localparam int unsigned OFS_LMASK1 = 32'h34;

    localparam int unsigned NCPU = 2;

    // Decode a word index (byte offset divided by four).
    function automatic reg_sel_e decode_word(input int unsigned widx);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (widx == OFS_CAUSE / 4)       sel = SEL_CAUSE;
        else if (widx == OFS_EMASK0 / 4) sel = SEL_EMASK0;
        else if (widx == OFS_LMASK0 / 4) sel = SEL_LMASK0;
        else if (widx == OFS_EMASK1 / 4) sel = SEL_EMASK1;
        else if (widx == OFS_LMASK1 / 4) sel = SEL_LMASK1;
        return sel;
    endfunction

endpackage

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] level_in,
    input  logic              ack_wr,
    input  logic [NLINES-1:0] ack_data,
    output logic [NLINES-1:0] edge_hit,
    output logic [NLINES-1:0] cause
);

    logic [NLINES-1:0] prev_q;
    logic [NLINES-1:0] cause_q;
    logic [NLINES-1:0] keep_mask;
    logic [NLINES-1:0] cause_d;

    assign edge_hit  = level_in & ~prev_q;
    assign keep_mask = ack_wr ? ack_data : {NLINES{1'b1}};
    // A fresh event wins over a clearing write in the same cycle.
    assign cause_d   = (cause_q & keep_mask) | edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= level_in;
            cause_q <= cause_d;
        end
    end

    assign cause = cause_q;

    // R4: every detected rising edge is present in the cause register next cycle
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((cause & $past(edge_hit)) == $past(edge_hit)));

    // R4: no cause bit appears without a rising edge
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & ~$past(cause) & ~$past(edge_hit)) == '0));

    // R5: bits written as 0 are gone after the write unless a new edge arrived
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((cause & ~$past(ack_data) & ~$past(edge_hit)) == '0));

    // R9: a colliding edge survives a clearing write
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && ((edge_hit & ~ack_data) != '0))
        |=> ((cause & $past(edge_hit & ~ack_data)) == $past(edge_hit & ~ack_data)));

endmodule

// File: rtl/pin_irq_cpu_mask.sv
module pin_irq_cpu_mask #(
    parameter int NLINES  = 32,
    parameter int GROUP_W = 8,
    localparam int NGROUPS = NLINES / GROUP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_edge,
    input  logic               wr_level,
    input  logic [NLINES-1:0]  wr_data,
    input  logic [NLINES-1:0]  level_in,
    input  logic [NLINES-1:0]  cause,
    output logic [NLINES-1:0]  emask,
    output logic [NLINES-1:0]  lmask,
    output logic [NGROUPS-1:0] irq
);

    logic [NLINES-1:0]  emask_q;
    logic [NLINES-1:0]  lmask_q;
    logic [NLINES-1:0]  req;
    logic [NGROUPS-1:0] grp_any;
    logic [NGROUPS-1:0] irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emask_q <= '0;
            lmask_q <= '0;
        end else begin
            if (wr_edge)  emask_q <= wr_data;
            if (wr_level) lmask_q <= wr_data;
        end
    end

    assign req = (level_in & lmask_q) | (cause & emask_q);

    for (genvar g = 0; g < NGROUPS; g++) begin : g_group
        assign grp_any[g] = |req[g*GROUP_W +: GROUP_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= grp_any;
    end

    assign emask = emask_q;
    assign lmask = lmask_q;
    assign irq   = irq_q;

    // R3: with both masks clear, no request is raised next cycle
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((emask_q == '0) && (lmask_q == '0)) |=> (irq == '0));

    // R3: an enabled high level always raises some request next cycle
    p_level_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((level_in & lmask_q) != '0) |=> (irq != '0));

    // R6: an enabled pending cause always raises some request next cycle
    p_cause_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & emask_q) != '0) |=> (irq != '0));

endmodule

// File: rtl/pin_irq_aggregator.sv
module pin_irq_aggregator
    import pin_irq_pkg::*;
#(
    parameter int NLINES  = 32,
    parameter int GROUP_W = 8,
    parameter int ADDR_W  = 8,
    localparam int NGROUPS = NLINES / GROUP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLINES-1:0]  level_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NLINES-1:0]  reg_wdata,
    output logic [NLINES-1:0]  reg_rdata,
    output logic [NGROUPS-1:0] irq_cpu0,
    output logic [NGROUPS-1:0] irq_cpu1
);

    reg_sel_e          sel;
    logic [NLINES-1:0] edge_hit;
    logic [NLINES-1:0] cause;
    logic [NLINES-1:0] emask_all [NCPU];
    logic [NLINES-1:0] lmask_all [NCPU];
    logic [NGROUPS-1:0] irq_all  [NCPU];
    logic [NLINES-1:0] rdata_q;

    assign sel = decode_word(int'(reg_addr[ADDR_W-1:2]));

    pin_irq_edge #(.NLINES(NLINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (level_in),
        .ack_wr   (reg_wr && (sel == SEL_CAUSE)),
        .ack_data (reg_wdata),
        .edge_hit (edge_hit),
        .cause    (cause)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        localparam reg_sel_e EM_SEL = (c == 0) ? SEL_EMASK0 : SEL_EMASK1;
        localparam reg_sel_e LM_SEL = (c == 0) ? SEL_LMASK0 : SEL_LMASK1;
        pin_irq_cpu_mask #(.NLINES(NLINES), .GROUP_W(GROUP_W)) u_mask (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_edge  (reg_wr && (sel == EM_SEL)),
            .wr_level (reg_wr && (sel == LM_SEL)),
            .wr_data  (reg_wdata),
            .level_in (level_in),
            .cause    (cause),
            .emask    (emask_all[c]),
            .lmask    (lmask_all[c]),
            .irq      (irq_all[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            unique case (sel)
                SEL_CAUSE:  rdata_q <= cause;
                SEL_EMASK0: rdata_q <= emask_all[0];
                SEL_LMASK0: rdata_q <= lmask_all[0];
                SEL_EMASK1: rdata_q <= emask_all[1];
                SEL_LMASK1: rdata_q <= lmask_all[1];
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_cpu0  = irq_all[0];
    assign irq_cpu1  = irq_all[1];

    // R2: a read of an unmapped offset returns zero
    p_hole_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (sel == SEL_NONE)) |=> (reg_rdata == '0));

    // R2: read data holds when no read is issued
    p_rdata_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/pin_irq_aggregator_test.sv
module pin_irq_aggregator_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;
    localparam int GW = 8;
    localparam int NG = NL / GW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] level_in = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [NL-1:0] reg_wdata = '0;
    logic [NL-1:0] reg_rdata;
    logic [NG-1:0] irq_cpu0;
    logic [NG-1:0] irq_cpu1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    pin_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .level_in(level_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] irq_of(input int c);
        return (c == 0) ? {28'b0, irq_cpu0} : {28'b0, irq_cpu1};
    endfunction

    function automatic logic [7:0] em_ofs(input int c);
        return (c == 0) ? 8'h18 : 8'h30;
    endfunction

    function automatic logic [7:0] lm_ofs(input int c);
        return (c == 0) ? 8'h1C : 8'h34;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements): actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] pat;
        logic [31:0] grp;

        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check("R1 irq0", irq_of(0), 32'h0);
        check("R1 irq1", irq_of(1), 32'h0);
        bus_read(8'h14, rd); check("R1 cause", rd, 32'h0);
        bus_read(8'h18, rd); check("R1 emask0", rd, 32'h0);
        bus_read(8'h1C, rd); check("R1 lmask0", rd, 32'h0);
        bus_read(8'h30, rd); check("R1 emask1", rd, 32'h0);
        bus_read(8'h34, rd); check("R1 lmask1", rd, 32'h0);

        // R2: map, read-back, holes
        bus_write(8'h18, 32'hA5A5_0F0F);
        bus_write(8'h1C, 32'h1234_5678);
        bus_write(8'h30, 32'hDEAD_BEEF);
        bus_write(8'h35, 32'h0F0F_F0F0);   // low address bits ignored
        bus_write(8'h14, 32'hFFFF_FFFF);   // cause cannot be set by software
        foreach (pat[k]) begin end
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_read(8'h18, rd); check("R2 emask0", rd, 32'hA5A5_0F0F);
        bus_read(8'h1C, rd); check("R2 lmask0", rd, 32'h1234_5678);
        bus_read(8'h30, rd); check("R2 emask1", rd, 32'hDEAD_BEEF);
        bus_read(8'h34, rd); check("R2 lmask1", rd, 32'h0F0F_F0F0);
        bus_read(8'h14, rd); check("R2 cause", rd, 32'h0);
        bus_read(8'h10, rd); check("R2 hole10", rd, 32'h0);
        bus_read(8'h20, rd); check("R2 hole20", rd, 32'h0);
        bus_read(8'h3C, rd); check("R2 hole3C", rd, 32'h0);
        check("R2 irq0 idle", irq_of(0), 32'h0);
        for (int c = 0; c < 2; c++) begin
            bus_write(em_ofs(c), 32'h0);
            bus_write(lm_ofs(c), 32'h0);
        end

        // R3 / R7: level sweep over every line on both processors
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NL; i++) begin
                grp = 32'h1 << (i / GW);
                bus_write(lm_ofs(c), 32'h1 << i);
                level_in = 32'h1 << i;
                idle(1);
                check("R7 level group", irq_of(c), grp);
                check("R3 other cpu", irq_of(1 - c), 32'h0);
                level_in = '0;
                idle(1);
                check("R3 not latched", irq_of(c), 32'h0);
            end
            bus_write(lm_ofs(c), 32'h0);
        end
        level_in = '1;
        idle(2);
        check("R3 unmasked level", irq_of(0) | irq_of(1), 32'h0);
        level_in = '0;
        bus_write(8'h14, 32'h0);

        // R4 / R5 / R6 / R8: edge sweep
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NL; i++) begin
                grp = 32'h1 << (i / GW);
                bus_write(em_ofs(c), 32'h1 << i);
                bus_write(em_ofs(1 - c), ~(32'h1 << i));
                level_in = 32'h1 << i;
                idle(2);
                check("R6 edge group", irq_of(c), grp);
                check("R8 other cpu masked", irq_of(1 - c), 32'h0);
                level_in = '0;
                idle(2);
                check("R6 latched", irq_of(c), grp);
                bus_read(8'h14, rd); check("R4 cause bit", rd, 32'h1 << i);
                bus_write(8'h14, ~(32'h1 << i));
                idle(1);
                check("R5 ack drops irq", irq_of(c), 32'h0);
            end
            bus_write(em_ofs(0), 32'h0);
            bus_write(em_ofs(1), 32'h0);
        end

        // R5 partial acknowledge, R4 held and falling inputs
        pat = 32'h8000_2021;
        level_in = pat;
        idle(1);
        bus_read(8'h14, rd); check("R4 multi edge", rd, pat);
        bus_write(8'h14, ~32'h0000_0020);
        bus_read(8'h14, rd); check("R5 partial ack", rd, pat & ~32'h20);
        idle(3);
        bus_read(8'h14, rd); check("R4 held no retrigger", rd, pat & ~32'h20);
        bus_write(8'h14, 32'h0);
        bus_read(8'h14, rd); check("R5 clear all", rd, 32'h0);
        level_in = '0;
        idle(2);
        bus_read(8'h14, rd); check("R4 falling ignored", rd, 32'h0);

        // R9: edge and clearing write in the same cycle
        level_in = 32'h1 << 3;
        idle(1);
        level_in = '0;
        idle(1);
        @(negedge clk);
        level_in = 32'h1 << 7;
        reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        bus_read(8'h14, rd); check("R9 collision", rd, 32'h1 << 7);
        bus_write(8'h14, 32'h0);
        level_in = '0;
        bus_read(8'h14, rd); check("R9 cleanup", rd, 32'h0);

        // R8: shared cause seen by both processors, one ack clears both
        bus_write(8'h18, 32'h1 << 20);
        bus_write(8'h30, 32'h1 << 20);
        level_in = 32'h1 << 20;
        idle(2);
        check("R8 shared irq0", irq_of(0), 32'h4);
        check("R8 shared irq1", irq_of(1), 32'h4);
        bus_write(8'h14, ~(32'h1 << 20));
        idle(1);
        check("R8 ack irq0", irq_of(0), 32'h0);
        check("R8 ack irq1", irq_of(1), 32'h0);
        level_in = '0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule